// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Slave Store

This block sits between an instruction fetch unit and a slow main memory. It keeps 32 recently fetched words. Each word goes into the entry picked by the low five bits of its fetch address, and the rest of the address is stored with it as a tag. A fetch that finds a valid entry with a matching tag gets its answer from the store one cycle later, and main memory is not used. A fetch that misses reads main memory over a request/acknowledge port with any latency. The word is then returned and written into the entry.

Memory returns a parity bit with every read word, and the entry keeps that bit. A hit whose word no longer agrees with its parity bit raises a one-cycle fault pulse. The entry is then dropped and the word is read again from memory. The CPU's stores go through the same memory port. When a store's address matches a valid entry, that entry takes the new data, so a program that rewrites all of memory leaves the store consistent with it. A flush input empties the whole store in one cycle.

Top module: `ifetch_slave_store`

## Requirements
- R1: After reset no entry is valid, every output pulse is low, and the first fetch to any address reads main memory.
- R2: The entry index is fetch address bits [4:0] and the tag is all higher bits. A fetch with the same index but a different tag misses and replaces the entry.
- R3: A fetch that hits a valid, matching, parity-correct entry raises `fetch_done` with `fetch_hit`=1 and the stored word in the cycle after the request is taken. It issues no memory request.
- R4: A fetch that misses issues a memory read (`mem_we`=0) at the fetch address and returns `mem_rdata` with `fetch_hit`=0. It fills the entry, so that a repeat fetch of that address hits.
- R5: The memory request holds until `mem_ack`, and the fetch response comes in the cycle after the acknowledge. A miss with an acknowledge N cycles after the request therefore takes N+1 cycles from request to response.
- R6: Parity is even over the data word: the parity bit equals the XOR of all 48 data bits. A hit whose stored bit disagrees pulses `parity_fault` for exactly one cycle and invalidates the entry. The fetch is then served from memory with `fetch_hit`=0. A miss fill never raises the fault.
- R7: A store writes main memory (`mem_we`=1) and ends with a `store_done` pulse in the cycle after the acknowledge. If a valid entry matches the store address in index and tag, the entry takes the store data, and a later fetch of that address hits and returns it.
- R8: A store whose tag does not match the indexed entry leaves that entry unchanged.
- R9: A one-cycle `flush` pulse invalidates all entries, so that the next fetch of any address misses.
- R10: When a fetch and a store are requested in the same idle cycle, the fetch is served first and the store afterwards. `fetch_done` and `store_done` are never high together.
- R11: While `mem_req` is high and not acknowledged, `mem_req`, `mem_addr` and `mem_we` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry |
| fetch_req | input | 1 | Fetch request, held until `fetch_done` |
| fetch_addr | input | ADDR_W | Fetch word address |
| fetch_done | output | 1 | Fetch response pulse |
| fetch_data | output | DATA_W | Fetched word, valid with `fetch_done` |
| fetch_hit | output | 1 | Response was served from the store |
| store_req | input | 1 | CPU store request, held until `store_done` |
| store_addr | input | ADDR_W | Store word address |
| store_data | input | DATA_W | Store data |
| store_done | output | 1 | Store completion pulse |
| mem_req | output | 1 | Main memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Main memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| mem_rpar | input | 1 | Parity bit of `mem_rdata` |
| parity_fault | output | 1 | Parity fault interrupt pulse |

## Verification
The bound checker watches every cycle for these properties:
- a taken hit is answered in the next cycle without a memory request;
- every acknowledged read or write produces its completion pulse;
- the memory request stays stable while it waits;
- a parity fault is a lone pulse that coincides with the re-read;
- the two completion pulses never overlap.

Only the bench's scenarios can show the following:
- whether the returned data is the right word;
- that a same-index, different-tag fetch evicts the entry;
- that a store updates a matching entry and leaves a non-matching one alone;
- that a flush forces misses;
- the exact miss latency under several memory delays.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RESP  = 2'd3
  } ss_state_t;
endpackage

// File: rtl/ss_array.sv
module ss_array #(
  parameter int IDX_W  = 5,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_par,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_par,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] valid;
  logic [TAG_W-1:0]   tag_mem  [ENTRIES];
  logic [DATA_W-1:0]  data_mem [ENTRIES];
  logic               par_mem  [ENTRIES];

  // Valid bits: flush beats a fill, and a fill beats an invalidate.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_valid
    always_ff @(posedge clk) begin
      if (!rst_n || flush)                          valid[e] <= 1'b0;
      else if (wr_en && wr_idx == IDX_W'(e))        valid[e] <= 1'b1;
      else if (inv_en && inv_idx == IDX_W'(e))      valid[e] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
      par_mem[wr_idx]  <= wr_par;
    end
  end

  assign rd_valid = valid[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_data  = data_mem[rd_idx];
  assign rd_par   = par_mem[rd_idx];
endmodule

// File: rtl/ss_ctrl.sv
module ss_ctrl
  import ss_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_req,
  input  logic store_req,
  input  logic look_hit,
  input  logic look_fault,
  input  logic mem_ack,
  output logic st_idle,
  output logic take_fetch,
  output logic take_store,
  output logic mem_req,
  output logic mem_we,
  output logic rsp_fetch,
  output logic rsp_store,
  output logic fault_pulse
);
  ss_state_t state, state_nx;
  logic      op_store;

  assign st_idle    = (state == ST_IDLE);
  assign take_fetch = st_idle && fetch_req;
  assign take_store = st_idle && !fetch_req && store_req;
  assign mem_req    = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we     = (state == ST_WRITE);
  assign rsp_fetch  = (state == ST_RESP) && !op_store;
  assign rsp_store  = (state == ST_RESP) && op_store;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: begin
        if (take_fetch)      state_nx = look_hit ? ST_RESP : ST_READ;
        else if (take_store) state_nx = ST_WRITE;
      end
      ST_READ:  if (mem_ack) state_nx = ST_RESP;
      ST_WRITE: if (mem_ack) state_nx = ST_RESP;
      ST_RESP:  state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      op_store    <= 1'b0;
      fault_pulse <= 1'b0;
    end else begin
      state       <= state_nx;
      fault_pulse <= take_fetch && look_fault;
      if (take_fetch || take_store) op_store <= take_store;
    end
  end
endmodule

// File: rtl/ifetch_slave_store.sv
module ifetch_slave_store #(
  parameter int ADDR_W = 18,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_done,
  output logic [DATA_W-1:0] fetch_data,
  output logic              fetch_hit,
  input  logic              store_req,
  input  logic [ADDR_W-1:0] store_addr,
  input  logic [DATA_W-1:0] store_data,
  output logic              store_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rpar,
  output logic              parity_fault
);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  function automatic logic par_of(input logic [DATA_W-1:0] w);
    return ^w;
  endfunction

  logic              st_idle, take_fetch, take_store, rsp_fetch, rsp_store;
  logic              look_hit, look_fault, tag_match, par_ok;
  logic [ADDR_W-1:0] op_addr, look_addr;
  logic [DATA_W-1:0] op_data, rsp_data;
  logic              hit_q;
  logic              rd_valid, rd_par;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              fill_evt, update_evt, wr_en;
  logic [DATA_W-1:0] wr_data;
  logic              wr_par;

  // Idle: look up the incoming request. Busy: look up the latched op.
  assign look_addr  = !st_idle ? op_addr : (fetch_req ? fetch_addr : store_addr);
  assign tag_match  = rd_valid && (rd_tag == tag_of(look_addr));
  assign par_ok     = (par_of(rd_data) == rd_par);
  assign look_hit   = tag_match && par_ok;
  assign look_fault = tag_match && !par_ok;

  assign fill_evt   = mem_req && !mem_we && mem_ack;
  assign update_evt = mem_req && mem_we && mem_ack && tag_match;
  assign wr_en      = fill_evt || update_evt;
  assign wr_data    = fill_evt ? mem_rdata : op_data;
  assign wr_par     = fill_evt ? mem_rpar : par_of(op_data);

  ss_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .store_req   (store_req),
    .look_hit    (look_hit),
    .look_fault  (look_fault),
    .mem_ack     (mem_ack),
    .st_idle     (st_idle),
    .take_fetch  (take_fetch),
    .take_store  (take_store),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .rsp_fetch   (rsp_fetch),
    .rsp_store   (rsp_store),
    .fault_pulse (parity_fault)
  );

  ss_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .rd_idx   (idx_of(look_addr)),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_data  (rd_data),
    .rd_par   (rd_par),
    .wr_en    (wr_en),
    .wr_idx   (idx_of(op_addr)),
    .wr_tag   (tag_of(op_addr)),
    .wr_data  (wr_data),
    .wr_par   (wr_par),
    .inv_en   (take_fetch && look_fault),
    .inv_idx  (idx_of(look_addr))
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_addr  <= '0;
      op_data  <= '0;
      rsp_data <= '0;
      hit_q    <= 1'b0;
    end else begin
      if (take_fetch) begin
        op_addr <= fetch_addr;
        hit_q   <= look_hit;
        if (look_hit) rsp_data <= rd_data;
      end else if (take_store) begin
        op_addr <= store_addr;
        op_data <= store_data;
      end
      if (fill_evt) rsp_data <= mem_rdata;
    end
  end

  assign fetch_done = rsp_fetch;
  assign fetch_data = rsp_data;
  assign fetch_hit  = rsp_fetch && hit_q;
  assign store_done = rsp_store;
  assign mem_addr   = op_addr;
  assign mem_wdata  = op_data;
endmodule

// File: rtl/ss_checker.sv
module ss_checker #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fetch_done,
  input logic              fetch_hit,
  input logic              store_done,
  input logic              parity_fault,
  input logic              take_fetch,
  input logic              look_hit
);
  // R3
  hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_fetch && look_hit |=> fetch_done && fetch_hit && !mem_req);

  // R5
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> fetch_done && !fetch_hit);

  // R7
  store_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> store_done && !fetch_done);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R6
  fault_reread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_fault |-> mem_req && !mem_we);

  // R6
  fault_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_fault |=> !parity_fault);

  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_done && store_done));
endmodule

bind ifetch_slave_store ss_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .fetch_done   (fetch_done),
  .fetch_hit    (fetch_hit),
  .store_done   (store_done),
  .parity_fault (parity_fault),
  .take_fetch   (take_fetch),
  .look_hit     (look_hit)
);

// File: tb/ifetch_slave_store_tb.sv
module ifetch_slave_store_tb;
  localparam int AW = 12;
  localparam int DW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic fetch_req = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic fetch_done, fetch_hit, store_done, mem_req, mem_we, parity_fault;
  logic [DW-1:0] fetch_data, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic store_req = 1'b0;
  logic [AW-1:0] store_addr = '0;
  logic [DW-1:0] store_data = '0;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_rpar = 1'b0;

  always #10 clk = ~clk;

  ifetch_slave_store #(.ADDR_W(AW), .IDX_W(5), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_done(fetch_done),
    .fetch_data(fetch_data), .fetch_hit(fetch_hit),
    .store_req(store_req), .store_addr(store_addr), .store_data(store_data),
    .store_done(store_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_rpar(mem_rpar),
    .parity_fault(parity_fault)
  );

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  int wr_count = 0;
  int fault_count = 0;
  int mem_lat = 1;
  int lat_cnt = 0;
  int cyc_total = 0;
  logic [DW-1:0] mem [1<<AW];
  logic bad_par [1<<AW];

  // Model word: a spread of the address bits so neighbours differ.
  function automatic logic [DW-1:0] init_word(input int a);
    logic [DW-1:0] w;
    w = {16'(a * 37) ^ 16'hA5C3, 20'(a * 3 + 7), 12'(a)};
    return w;
  endfunction

  initial begin
    for (int a = 0; a < (1 << AW); a++) begin
      mem[a] = init_word(a);
      bad_par[a] = 1'b0;
    end
  end

  // Memory model: acknowledge mem_lat cycles after the request is seen.
  always @(negedge clk) begin
    cyc_total++;
    if (parity_fault) fault_count++;
    if (mem_ack) begin
      mem_ack = 1'b0;
      lat_cnt = 0;
    end else if (mem_req) begin
      if (lat_cnt == mem_lat - 1) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_count++;
        end else begin
          mem_rdata = mem[mem_addr];
          mem_rpar  = (^mem[mem_addr]) ^ bad_par[mem_addr];
          rd_count++;
        end
      end else begin
        lat_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (cyc_total > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc_total);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [AW-1:0] a, output logic [DW-1:0] d,
                          output logic h, output int cyc);
    fetch_addr = a;
    fetch_req  = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!fetch_done && cyc < 1000);
    d = fetch_data;
    h = fetch_hit;
    fetch_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n;
    store_addr = a;
    store_data = d;
    store_req  = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!store_done && n < 1000);
    store_req = 1'b0;
    chk(store_done === 1'b1, "R7 store completes", 64'(store_done), 64'd1);
    @(negedge clk);
  endtask

  // {address, expected hit}
  localparam logic [AW:0] VEC [8] = '{
    {12'h005, 1'b0}, {12'h005, 1'b1}, {12'h025, 1'b0}, {12'h005, 1'b0},
    {12'h01F, 1'b0}, {12'h01F, 1'b1}, {12'h025, 1'b0}, {12'h025, 1'b1}
  };

  initial begin
    logic [DW-1:0] d;
    logic h;
    int cyc, r0, f0, w0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(fetch_done === 1'b0 && store_done === 1'b0 && mem_req === 1'b0 && parity_fault === 1'b0,
        "R1 reset outputs", {fetch_done, store_done, mem_req, parity_fault}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: table walk with varying memory latency
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a;
      logic eh;
      a  = VEC[i][AW:1];
      eh = VEC[i][0];
      mem_lat = (i % 3) + 1;
      r0 = rd_count;
      do_fetch(a, d, h, cyc);
      chk(d === mem[a], "R4 fetch data", d, mem[a]);
      chk(h === eh, "R3 R2 hit flag", 64'(h), 64'(eh));
      chk(rd_count - r0 == (eh ? 0 : 1), "R3 R4 memory reads", 64'(rd_count - r0), 64'(eh ? 0 : 1));
      chk(cyc == (eh ? 1 : mem_lat + 1), "R5 R3 response latency", 64'(cyc), 64'(eh ? 1 : mem_lat + 1));
    end

    // R5: long latency
    mem_lat = 6;
    do_fetch(12'h100, d, h, cyc);
    chk(cyc == 7, "R5 long miss latency", 64'(cyc), 64'd7);
    chk(d === mem[12'h100], "R5 long miss data", d, mem[12'h100]);
    mem_lat = 2;

    // R6: bad parity word fills silently, then faults on hit
    bad_par[12'h040] = 1'b1;
    f0 = fault_count;
    do_fetch(12'h040, d, h, cyc);
    chk(fault_count == f0, "R6 no fault on miss fill", 64'(fault_count - f0), 64'd0);
    bad_par[12'h040] = 1'b0;
    r0 = rd_count;
    do_fetch(12'h040, d, h, cyc);
    chk(fault_count - f0 == 1, "R6 fault pulse once", 64'(fault_count - f0), 64'd1);
    chk(h === 1'b0, "R6 fault served as miss", 64'(h), 64'd0);
    chk(rd_count - r0 == 1, "R6 re-read from memory", 64'(rd_count - r0), 64'd1);
    chk(d === mem[12'h040], "R6 data after fault", d, mem[12'h040]);
    do_fetch(12'h040, d, h, cyc);
    chk(h === 1'b1 && fault_count - f0 == 1, "R6 refilled entry hits cleanly", 64'(h), 64'd1);

    // R7: store to a cached address updates the entry
    w0 = wr_count;
    do_store(12'h01F, 48'h1234_5678_9ABC);
    chk(wr_count - w0 == 1 && mem[12'h01F] === 48'h1234_5678_9ABC, "R7 memory written",
        mem[12'h01F], 48'h1234_5678_9ABC);
    r0 = rd_count;
    do_fetch(12'h01F, d, h, cyc);
    chk(h === 1'b1 && rd_count == r0, "R7 store keeps entry hit", 64'(h), 64'd1);
    chk(d === 48'h1234_5678_9ABC, "R7 updated data", d, 48'h1234_5678_9ABC);

    // R8: store with same index, different tag
    do_store(12'h03F, 48'hFEDC_BA98_7654);
    r0 = rd_count;
    do_fetch(12'h01F, d, h, cyc);
    chk(h === 1'b1 && d === 48'h1234_5678_9ABC, "R8 other tag leaves entry", d, 48'h1234_5678_9ABC);
    chk(rd_count == r0, "R8 no memory read", 64'(rd_count - r0), 64'd0);
    do_fetch(12'h03F, d, h, cyc);
    chk(h === 1'b0 && d === 48'hFEDC_BA98_7654, "R8 stored word from memory", d, 48'hFEDC_BA98_7654);

    // R9: flush empties every entry
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    do_fetch(12'h03F, d, h, cyc);
    chk(h === 1'b0, "R9 miss after flush a", 64'(h), 64'd0);
    do_fetch(12'h040, d, h, cyc);
    chk(h === 1'b0, "R9 miss after flush b", 64'(h), 64'd0);

    // R10: simultaneous fetch and store, fetch first
    begin
      bit fetch_seen, store_after, both;
      int n;
      fetch_seen = 0; store_after = 0; both = 0;
      fetch_addr = 12'h040;
      store_addr = 12'h200;
      store_data = 48'h0000_1111_2222;
      fetch_req = 1'b1;
      store_req = 1'b1;
      n = 0;
      while (!store_after && n < 200) begin
        @(negedge clk);
        n++;
        if (fetch_done && store_done) both = 1;
        if (fetch_done) begin
          fetch_seen = 1;
          fetch_req = 1'b0;
        end
        if (store_done) begin
          store_after = fetch_seen;
          store_req = 1'b0;
          if (!fetch_seen) n = 200;
        end
      end
      fetch_req = 1'b0;
      store_req = 1'b0;
      chk(store_after && !both, "R10 fetch served before store", 64'(store_after), 64'd1);
      @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule